// File: doc/BRIEF.md
# Multi-Sensor Temperature Threshold Monitor

This block watches the temperature samples of up to sixteen sensors. For each sensor it stores the most recent sample along with three limits: upper, lower and critical. Every time a new sample arrives, the block compares it against that sensor's limits. Any limit that is crossed sets a sticky status bit for that sensor and that violation type. Each status bit has a matching mask bit and a matching clear bit. The unmasked violations are then gathered into two level-sensitive interrupt lines. One line covers upper and lower violations. The other covers critical violations.

Samples come in on a dedicated write port. A converter sitting beside the block drives that port. Software reaches the limits, masks, clears, status and a control word through a synchronous register port, and read data returns one clock after the address is presented.

After a sample is stored, the sensor's valid flag stays low for a fixed number of clocks. Readers use this flag to know when the new sample can be taken. A global enable in the control word can shut the whole monitor down.

Top module: `tmon_monitor`

## Requirements
- R1: A stored sample sets the sensor's upper status (status bit 0) when the sample is at or above the sensor's upper limit (field 1).
- R2: A stored sample sets the lower status (status bit 1) when the sample is at or below the lower limit (field 2).
- R3: A stored sample sets the critical status (status bit 2) when the sample is at or above the critical limit (field 3).
- R4: Status bits are sticky. A later sample that lies inside all limits leaves a set bit set.
- R5: While a clear bit (field 5, same bit layout as status) holds 1, the matching status reads 0, even when violating samples arrive. Once the clear bit is written back to 0, new violations set the status again.
- R6: A mask bit (field 4, same layout) of 1 keeps that violation off its interrupt line. The status bit is still recorded.
- R7: `irq_ul` is high one clock after any sensor holds an unmasked, enabled upper or lower status. It falls once no such status remains.
- R8: `irq_crit` is a separate line, driven only by unmasked, enabled critical status.
- R9: Control word (field 7) bits [3:1] enable the upper, lower and critical interrupt sources respectively. Writing 0 to these bits silences both lines. Writing 7 to them enables all three.
- R10: After a sample is stored, `sens_valid` for that sensor is 0 for 6 clocks and then returns to 1. It is 0 from reset until the first sample.
- R11: Control bit 0 is the global enable, and it is 0 after reset. While it is 0, all status bits are 0, all valid flags are 0, and incoming samples are dropped.
- R12: The register address is {sensor index, field[2:0]}, and read data appears one clock later. The sample field (0) reads {valid, 3'b000, sample}. After reset the limits read 0x7FF (upper and critical) and 0x800 (lower).
- R13: Samples and limits are 12-bit two's-complement numbers and are compared as signed values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_we | input | 1 | Sample write strobe |
| smp_idx | input | IW | Sensor index of the incoming sample |
| smp_data | input | DW | Signed sample value |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IW+3 | {sensor index, field} |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW+4 | Registered read data |
| sens_valid | output | NS | Per-sensor sample-valid flags |
| irq_ul | output | 1 | Upper/lower violation interrupt, level |
| irq_crit | output | 1 | Critical violation interrupt, level |

## Verification
The assertions assume that `smp_idx` names an existing sensor whenever `smp_we` is high. They also assume that a clear bit is only ever the software's request, so a status bit may fall only through a clear or through the global enable. The stimulus writes samples only to configured sensors and leaves each clear bit high for at least one clock before it is released. Every status readback and interrupt check is timed to the register depth of the path it observes.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  typedef enum logic [2:0] {
    F_SAMPLE = 3'd0,
    F_UPPER  = 3'd1,
    F_LOWER  = 3'd2,
    F_CRIT   = 3'd3,
    F_MASK   = 3'd4,
    F_CLEAR  = 3'd5,
    F_STATUS = 3'd6,
    F_CTRL   = 3'd7
  } fld_e;

  localparam int unsigned VB_UP = 0;
  localparam int unsigned VB_LO = 1;
  localparam int unsigned VB_CR = 2;
  localparam int unsigned NTYPE = 3;
endpackage

// File: rtl/tmon_cmp.sv
module tmon_cmp #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] lim_up,
  input  logic [DW-1:0] lim_lo,
  input  logic [DW-1:0] lim_cr,
  output logic [2:0]    viol
);
  import tmon_pkg::*;

  always_comb begin
    viol        = '0;
    viol[VB_UP] = $signed(sample) >= $signed(lim_up);
    viol[VB_LO] = $signed(sample) <= $signed(lim_lo);
    viol[VB_CR] = $signed(sample) >= $signed(lim_cr);
  end
endmodule

// File: rtl/tmon_slice.sv
module tmon_slice #(
  parameter int HOLD = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gen,
  input  logic       hit,
  input  logic [2:0] viol,
  input  logic [2:0] clr,
  output logic [2:0] stat,
  output logic       valid
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !gen) begin
      stat  <= '0;
      cnt   <= '0;
      valid <= 1'b0;
    end else begin
      stat <= (stat | (hit ? viol : 3'b000)) & ~clr;
      if (hit) begin
        cnt   <= CW'(HOLD);
        valid <= 1'b0;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmon_irq.sv
module tmon_irq #(
  parameter int NS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    ien,
  input  logic [NS-1:0] st_up,
  input  logic [NS-1:0] st_lo,
  input  logic [NS-1:0] st_cr,
  input  logic [NS-1:0] mk_up,
  input  logic [NS-1:0] mk_lo,
  input  logic [NS-1:0] mk_cr,
  output logic          irq_ul,
  output logic          irq_crit
);
  logic [NS-1:0] live_up, live_lo, live_cr;

  assign live_up = st_up & ~mk_up & {NS{ien[0]}};
  assign live_lo = st_lo & ~mk_lo & {NS{ien[1]}};
  assign live_cr = st_cr & ~mk_cr & {NS{ien[2]}};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ul   <= 1'b0;
      irq_crit <= 1'b0;
    end else begin
      irq_ul   <= |(live_up | live_lo);
      irq_crit <= |live_cr;
    end
  end
endmodule

// File: rtl/tmon_monitor.sv
module tmon_monitor #(
  parameter int NS   = 16,
  parameter int DW   = 12,
  parameter int HOLD = 6,
  parameter int IW   = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_we,
  input  logic [IW-1:0]   smp_idx,
  input  logic [DW-1:0]   smp_data,
  input  logic            reg_we,
  input  logic [IW+2:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW+3:0]   reg_rdata,
  output logic [NS-1:0]   sens_valid,
  output logic            irq_ul,
  output logic            irq_crit
);
  import tmon_pkg::*;

  localparam int RDW = DW + 4;
  localparam logic [DW-1:0] LIM_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] LIM_MIN = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] lim_up [NS];
  logic [DW-1:0] lim_lo [NS];
  logic [DW-1:0] lim_cr [NS];
  logic [2:0]    mask_q [NS];
  logic [2:0]    clr_q  [NS];
  logic [DW-1:0] smp_mem [NS];
  logic          gen;
  logic [2:0]    ien;

  logic [IW-1:0] sidx;
  fld_e          fld;
  logic          sidx_ok, smp_ok, smp_acc;
  logic [2:0]    viol;

  logic [NS-1:0] st_up, st_lo, st_cr;
  logic [NS-1:0] clr_up, clr_lo, clr_cr;
  logic [NS-1:0] mk_up, mk_lo, mk_cr;

  assign sidx    = reg_addr[IW+2:3];
  assign fld     = fld_e'(reg_addr[2:0]);
  assign sidx_ok = {1'b0, sidx} < (IW+1)'(NS);
  assign smp_ok  = {1'b0, smp_idx} < (IW+1)'(NS);
  assign smp_acc = smp_we && gen && smp_ok;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      gen <= 1'b0;
      ien <= '0;
      for (int i = 0; i < NS; i++) begin
        lim_up[i] <= LIM_MAX;
        lim_lo[i] <= LIM_MIN;
        lim_cr[i] <= LIM_MAX;
        mask_q[i] <= '0;
        clr_q[i]  <= '0;
      end
    end else if (reg_we) begin
      if (fld == F_CTRL) begin
        gen <= reg_wdata[0];
        ien <= reg_wdata[3:1];
      end else if (sidx_ok) begin
        case (fld)
          F_UPPER: lim_up[sidx] <= reg_wdata;
          F_LOWER: lim_lo[sidx] <= reg_wdata;
          F_CRIT:  lim_cr[sidx] <= reg_wdata;
          F_MASK:  mask_q[sidx] <= reg_wdata[2:0];
          F_CLEAR: clr_q[sidx]  <= reg_wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  // Sample storage, no reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (smp_acc) smp_mem[smp_idx] <= smp_data;
  end

  tmon_cmp #(.DW(DW)) u_cmp (
    .sample (smp_data),
    .lim_up (lim_up[smp_idx]),
    .lim_lo (lim_lo[smp_idx]),
    .lim_cr (lim_cr[smp_idx]),
    .viol   (viol)
  );

  for (genvar g = 0; g < NS; g++) begin : g_sens
    logic [2:0] stat_g;

    tmon_slice #(.HOLD(HOLD)) u_slice (
      .clk   (clk),
      .rst   (rst),
      .gen   (gen),
      .hit   (smp_acc && (smp_idx == IW'(g))),
      .viol  (viol),
      .clr   (clr_q[g]),
      .stat  (stat_g),
      .valid (sens_valid[g])
    );

    assign st_up[g]  = stat_g[VB_UP];
    assign st_lo[g]  = stat_g[VB_LO];
    assign st_cr[g]  = stat_g[VB_CR];
    assign clr_up[g] = clr_q[g][VB_UP];
    assign clr_lo[g] = clr_q[g][VB_LO];
    assign clr_cr[g] = clr_q[g][VB_CR];
    assign mk_up[g]  = mask_q[g][VB_UP];
    assign mk_lo[g]  = mask_q[g][VB_LO];
    assign mk_cr[g]  = mask_q[g][VB_CR];
  end

  tmon_irq #(.NS(NS)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .ien      (ien),
    .st_up    (st_up),
    .st_lo    (st_lo),
    .st_cr    (st_cr),
    .mk_up    (mk_up),
    .mk_lo    (mk_lo),
    .mk_cr    (mk_cr),
    .irq_ul   (irq_ul),
    .irq_crit (irq_crit)
  );

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (fld == F_CTRL) begin
      reg_rdata <= RDW'({ien, gen});
    end else if (!sidx_ok) begin
      reg_rdata <= '0;
    end else begin
      case (fld)
        F_SAMPLE: reg_rdata <= {sens_valid[sidx], 3'b000, smp_mem[sidx]};
        F_UPPER:  reg_rdata <= RDW'(lim_up[sidx]);
        F_LOWER:  reg_rdata <= RDW'(lim_lo[sidx]);
        F_CRIT:   reg_rdata <= RDW'(lim_cr[sidx]);
        F_MASK:   reg_rdata <= RDW'(mask_q[sidx]);
        F_CLEAR:  reg_rdata <= RDW'(clr_q[sidx]);
        F_STATUS: reg_rdata <= RDW'({st_cr[sidx], st_lo[sidx], st_up[sidx]});
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmon_monitor_sva.sv
module tmon_monitor_sva #(
  parameter int NS = 16,
  parameter int IW = (NS > 1) ? $clog2(NS) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          gen,
  input logic          smp_we,
  input logic [IW-1:0] smp_idx,
  input logic [NS-1:0] sens_valid,
  input logic          irq_ul,
  input logic          irq_crit,
  input logic [NS-1:0] st_up,
  input logic [NS-1:0] st_lo,
  input logic [NS-1:0] st_cr,
  input logic [NS-1:0] clr_up,
  input logic [NS-1:0] clr_lo,
  input logic [NS-1:0] clr_cr
);
  logic [3*NS-1:0] st_all, clr_all;
  assign st_all  = {st_cr, st_lo, st_up};
  assign clr_all = {clr_cr, clr_lo, clr_up};

  assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    gen |=> (($past(st_all) & ~$past(clr_all) & ~st_all) == '0));

  assert_clear_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (|clr_all) |=> ((st_all & $past(clr_all)) == '0));

  assert_ul_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_ul) |-> $past((|st_up) || (|st_lo)));

  assert_crit_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_crit) |-> $past(|st_cr));

  assert_valid_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (smp_we && gen && ({1'b0, smp_idx} < (IW+1)'(NS))) |=> !sens_valid[$past(smp_idx)]);

  assert_disable_R11: assert property (@(posedge clk) disable iff (rst)
    !gen |=> (st_all == '0 && sens_valid == '0));
endmodule

bind tmon_monitor tmon_monitor_sva #(.NS(NS)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .gen        (gen),
  .smp_we     (smp_we),
  .smp_idx    (smp_idx),
  .sens_valid (sens_valid),
  .irq_ul     (irq_ul),
  .irq_crit   (irq_crit),
  .st_up      (st_up),
  .st_lo      (st_lo),
  .st_cr      (st_cr),
  .clr_up     (clr_up),
  .clr_lo     (clr_lo),
  .clr_cr     (clr_cr)
);

// File: tb/tmon_monitor_bench.sv
`timescale 1ns/1ps
module tmon_monitor_bench;
  localparam int NS = 16;
  localparam int DW = 12;
  localparam int IW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            smp_we = 1'b0;
  logic [IW-1:0]   smp_idx = '0;
  logic [DW-1:0]   smp_data = '0;
  logic            reg_we = 1'b0;
  logic [IW+2:0]   reg_addr = '0;
  logic [DW-1:0]   reg_wdata = '0;
  logic [DW+3:0]   reg_rdata;
  logic [NS-1:0]   sens_valid;
  logic            irq_ul, irq_crit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmon_monitor #(.NS(NS), .DW(DW), .HOLD(6)) u_tmon_monitor (
    .clk, .rst, .smp_we, .smp_idx, .smp_data, .reg_we, .reg_addr,
    .reg_wdata, .reg_rdata, .sens_valid, .irq_ul, .irq_crit
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int s, int f, int v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {IW'(s), 3'(f)}; reg_wdata = DW'(v);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int s, int f, output int v);
    @(negedge clk);
    reg_addr = {IW'(s), 3'(f)};
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic put(int s, int v);
    @(negedge clk);
    smp_we = 1'b1; smp_idx = IW'(s); smp_data = DW'(v);
    @(negedge clk);
    smp_we = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    chk("R7 irq_ul reset", int'(irq_ul), 0);
    chk("R8 irq_crit reset", int'(irq_crit), 0);
    chk("R10 valid reset", int'(sens_valid), 0);
    rd(0, 7, v); chk("R11 ctrl reset", v, 0);
    rd(2, 1, v); chk("R12 upper reset", v, 'h7FF);
    rd(2, 2, v); chk("R12 lower reset", v, 'h800);
  endtask

  task automatic t_config();
    wr(0, 7, 'hF);
    for (int s = 3; s <= 5; s += 2) begin
      wr(s, 1, 100); wr(s, 2, -50); wr(s, 3, 200);
    end
  endtask

  task automatic t_upper();
    int v;
    put(3, 99); settle();
    rd(3, 6, v); chk("R1 below upper", v, 0);
    chk("R7 no irq", int'(irq_ul), 0);
    put(3, 100); @(negedge clk);
    chk("R7 irq_ul raised", int'(irq_ul), 1);
    chk("R8 crit quiet", int'(irq_crit), 0);
    rd(3, 6, v); chk("R1 at upper", v, 1);
  endtask

  task automatic t_signed();
    int v;
    put(5, -1); settle();
    rd(5, 6, v); chk("R13 signed -1", v, 0);
  endtask

  task automatic t_sticky();
    int v;
    put(3, 0); settle();
    rd(3, 6, v); chk("R4 sticky", v, 1);
  endtask

  task automatic t_clear();
    int v;
    wr(3, 5, 1); settle();
    rd(3, 6, v); chk("R5 cleared", v, 0);
    chk("R7 irq_ul fell", int'(irq_ul), 0);
    put(3, 150); settle();
    rd(3, 6, v); chk("R5 held clear", v, 0);
    wr(3, 5, 0);
    put(3, 150); settle();
    rd(3, 6, v); chk("R5 rearmed", v, 1);
    chk("R7 irq_ul again", int'(irq_ul), 1);
    wr(3, 5, 7); wr(3, 5, 0); settle();
    rd(3, 6, v); chk("R5 clear all", v, 0);
  endtask

  task automatic t_lower();
    int v;
    put(5, -49); settle();
    rd(5, 6, v); chk("R2 above lower", v, 0);
    put(5, -50); settle();
    rd(5, 6, v); chk("R2 at lower", v, 2);
    chk("R7 lower drives irq_ul", int'(irq_ul), 1);
  endtask

  task automatic t_crit();
    int v;
    put(3, 200); settle();
    rd(3, 6, v); chk("R3 crit+upper", v, 5);
    chk("R8 irq_crit", int'(irq_crit), 1);
  endtask

  task automatic t_mask();
    int v;
    wr(3, 4, 4); settle();
    chk("R6 crit masked", int'(irq_crit), 0);
    rd(3, 6, v); chk("R6 status kept", v, 5);
    wr(3, 4, 5); settle();
    chk("R6 lower still live", int'(irq_ul), 1);
    wr(5, 4, 2); settle();
    chk("R6 all ul masked", int'(irq_ul), 0);
    wr(3, 4, 0); wr(5, 4, 0); settle();
    chk("R6 unmasked ul", int'(irq_ul), 1);
    chk("R6 unmasked crit", int'(irq_crit), 1);
  endtask

  task automatic t_ien();
    wr(0, 7, 'h1); settle();
    chk("R9 ul off", int'(irq_ul), 0);
    chk("R9 crit off", int'(irq_crit), 0);
    wr(0, 7, 'h9); settle();
    chk("R9 ul stays off", int'(irq_ul), 0);
    chk("R9 crit only", int'(irq_crit), 1);
    wr(0, 7, 'hF); settle();
    chk("R9 all on", int'(irq_ul), 1);
  endtask

  task automatic t_valid();
    int v;
    chk("R10 unsampled", int'(sens_valid[9]), 0);
    put(7, 42);
    chk("R10 drop", int'(sens_valid[7]), 0);
    repeat (5) @(negedge clk);
    chk("R10 still low", int'(sens_valid[7]), 0);
    @(negedge clk);
    chk("R10 back high", int'(sens_valid[7]), 1);
    rd(7, 0, v); chk("R12 sample field", v, 'h802A);
  endtask

  task automatic t_disable();
    int v;
    wr(0, 7, 0); settle();
    chk("R11 valid zero", int'(sens_valid), 0);
    chk("R11 irq_ul off", int'(irq_ul), 0);
    chk("R11 irq_crit off", int'(irq_crit), 0);
    rd(3, 6, v); chk("R11 status zero", v, 0);
    put(7, 5); settle();
    rd(7, 0, v); chk("R11 sample dropped", v, 'h002A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_config();
    t_upper();
    t_signed();
    t_sticky();
    t_clear();
    t_lower();
    t_crit();
    t_mask();
    t_ien();
    t_valid();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule